// File: doc/BRIEF.md
# Fetch Window Tracking Queue

This block keeps one record for every fetch window that is in flight between the fetch stage and retirement. Each record holds a 64-byte cache line address, the thread that owns it, up to two branch offsets with their valid bits, and a flag that marks the final record of that line. A cache line with no branches needs a single record. A line whose branches cannot all be carried by one predictor record asks for several consecutive records in one request. Records leave the queue strictly in allocation order as the covered instructions retire.

The storage is one circular array. In single-thread mode thread 0 owns all of it. In dual-thread mode the array is split into two equal halves, one for each thread, and each half wraps on its own. A per-thread flush cuts the queue back so that the given entry becomes the youngest. The partition mode can change only while the whole queue is empty.

Top module: `fetch_window_queue`

## Requirements
- R1: After reset the queue is empty and in single-thread mode: `smt_mode`=0, `head_valid`=0, and `full`=2'b10 (thread 1 reads as full while it has no partition).
- R2: An allocation request is accepted (`alloc_ok`=1 in the same cycle) only when all of these hold: `alloc_cnt` is 1 to 4, the thread owns a partition, the partition has at least `alloc_cnt` free entries before this cycle's retire, and no flush for the same thread is requested in the same cycle. `alloc_stall` = `alloc_valid` and not `alloc_ok`.
- R3: `alloc_idx` gives the physical index of the first entry of an accepted request. Entries follow one another and wrap inside the partition. The partition base is 0 for thread 0. In dual-thread mode the base is DEPTH/2 for thread 1, and each partition holds DEPTH/2 entries.
- R4: Entry k of a request (k = 0 to `alloc_cnt`-1) stores `alloc_line`, `alloc_tid`, branch valid bits `alloc_br_vld[2k+1:2k]`, and offsets `alloc_br_off` slices 2k and 2k+1 (6 bits each, slice j at bits 6j+5:6j). It is marked last when k = `alloc_cnt`-1.
- R5: The head outputs show the oldest entry of thread `retire_tid` (`head_valid`, `head_idx`, and the fields). `retire_valid` frees that entry and advances the head by one in allocation order. A retire on an empty thread is ignored.
- R6: `full[t]` is 1 when thread t holds as many entries as its partition: 64 in single-thread mode, 32 in dual-thread mode.
- R7: A flush of thread t at physical index i makes i the youngest entry. The tail moves to the next entry after i, and the younger entries are discarded in that cycle. A flush on an empty thread is ignored.
- R8: `smt_req` takes effect only in a cycle where both threads are empty and no allocation is accepted. The head and tail pointers then return to the partition bases.
- R9: In single-thread mode, requests for thread 1 are rejected and retire or flush requests for thread 1 are ignored.
- R10: An allocation and a retire of the same thread may fall in the same cycle. Both take effect. The allocation is judged on the occupancy before the retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smt_req | input | 1 | Requested partition mode (1 = two threads) |
| alloc_valid | input | 1 | Allocation request |
| alloc_tid | input | 1 | Requesting thread |
| alloc_cnt | input | 3 | Number of entries asked for (1 to 4) |
| alloc_line | input | 26 | Cache line address |
| alloc_br_vld | input | 8 | Branch valid bits, two per entry |
| alloc_br_off | input | 48 | Branch offsets, 6 bits each, two per entry |
| alloc_ok | output | 1 | Request accepted this cycle |
| alloc_stall | output | 1 | Request refused this cycle |
| alloc_idx | output | 6 | Physical index of the first allocated entry |
| retire_valid | input | 1 | Free the head entry of `retire_tid` |
| retire_tid | input | 1 | Thread for retire and head outputs |
| head_valid | output | 1 | Head entry of `retire_tid` is held |
| head_idx | output | 6 | Physical index of that head |
| head_line | output | 26 | Line address at the head |
| head_last | output | 1 | Head is the last entry of its line |
| head_tid | output | 1 | Thread stored at the head |
| head_br_vld | output | 2 | Branch valid bits at the head |
| head_br_off | output | 12 | Branch offsets at the head |
| flush_valid | input | 1 | Flush request |
| flush_tid | input | 1 | Thread to flush |
| flush_idx | input | 6 | Physical index that becomes the youngest entry |
| full | output | 2 | Per-thread full flags |
| smt_mode | output | 1 | Current partition mode |

## Verification
Allocation and retire of the same thread can fall in the same cycle, and so can a flush and a retire. Both pairs are provoked on purpose: a retire is issued together with an allocation into a full partition and then into a partition with one free slot. A long dual-thread run also mixes retires, flushes at varying depths (the head itself included), and allocations that collide with a flush of their own thread. A model in the bench tracks the pointers and stored contents of each partition. It judges acceptance, `alloc_idx`, full flags and every head field cycle by cycle.

// File: rtl/fwq_pkg.sv
package fwq_pkg;
  localparam int LINE_W     = 26;
  localparam int OFF_W      = 6;
  localparam int BR_PER_ENT = 2;
  localparam int MAX_ALLOC  = 4;
  localparam int N_W        = $clog2(MAX_ALLOC + 1);

  typedef struct packed {
    logic [LINE_W-1:0]                 line;
    logic                              tid;
    logic                              last;
    logic [BR_PER_ENT-1:0]             br_vld;
    logic [BR_PER_ENT-1:0][OFF_W-1:0]  br_off;
  } fw_entry_t;
endpackage

// File: rtl/fwq_ptr_ctl.sv
module fwq_ptr_ctl #(
  parameter int PTR_W = 6,
  parameter int CNT_W = 7,
  parameter int N_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [PTR_W-1:0] mask_i,
  input  logic [CNT_W-1:0] psize_i,
  input  logic             alloc_i,
  input  logic [N_W-1:0]   alloc_n_i,
  input  logic             retire_i,
  input  logic             flush_i,
  input  logic [PTR_W-1:0] flush_off_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] keep_o
);
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd;

  always_comb begin
    keep_o = CNT_W'((flush_off_i - head_q) & mask_i) + CNT_W'(1);
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    upd    = clr_i | alloc_i | retire_i | flush_i;
    if (clr_i) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      if (retire_i) head_d = (head_q + PTR_W'(1)) & mask_i;
      if (flush_i) begin
        tail_d = (flush_off_i + PTR_W'(1)) & mask_i;
        cnt_d  = keep_o - CNT_W'(retire_i);
      end else begin
        if (alloc_i) tail_d = (tail_q + PTR_W'(alloc_n_i)) & mask_i;
        cnt_d = cnt_q + (alloc_i ? CNT_W'(alloc_n_i) : '0) - CNT_W'(retire_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign cnt_o  = cnt_q;

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= psize_i);
endmodule

// File: rtl/fwq_store.sv
module fwq_store
  import fwq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PTR_W = 6,
  parameter int CNT_W = 7
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [MAX_ALLOC-1:0]             wr_en_i,
  input  logic [MAX_ALLOC-1:0][PTR_W-1:0]  wr_idx_i,
  input  fw_entry_t [MAX_ALLOC-1:0]        wr_data_i,
  input  logic                             ret_en_i,
  input  logic [PTR_W-1:0]                 ret_idx_i,
  input  logic [1:0]                       fl_en_i,
  input  logic [1:0][PTR_W-1:0]            fl_head_i,
  input  logic [1:0][CNT_W-1:0]            fl_keep_i,
  input  logic [PTR_W-1:0]                 mask_i,
  input  logic                             smt_i,
  input  logic [PTR_W-1:0]                 rd_idx_i,
  output logic [DEPTH-1:0]                 valid_o,
  output fw_entry_t                        rd_entry_o
);
  fw_entry_t        mem [DEPTH];
  fw_entry_t        sel [DEPTH];
  logic [DEPTH-1:0] hit, drop, valid_q, valid_d;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    localparam logic [PTR_W-1:0] IDX = PTR_W'(gi);
    logic [MAX_ALLOC-1:0] m;
    logic [1:0]           own, dr;
    fw_entry_t            d;

    for (genvar k = 0; k < MAX_ALLOC; k++) begin : g_wr
      assign m[k] = wr_en_i[k] && (wr_idx_i[k] == IDX);
    end

    always_comb begin
      d = wr_data_i[0];
      for (int k = 0; k < MAX_ALLOC; k++) if (m[k]) d = wr_data_i[k];
    end

    assign own[0] = !smt_i || !IDX[PTR_W-1];
    assign own[1] = smt_i && IDX[PTR_W-1];
    for (genvar t = 0; t < 2; t++) begin : g_fl
      assign dr[t] = fl_en_i[t] && own[t] &&
                     (CNT_W'((IDX - fl_head_i[t]) & mask_i) >= fl_keep_i[t]);
    end

    assign hit[gi]  = |m;
    assign sel[gi]  = d;
    assign drop[gi] = (|dr) || (ret_en_i && (ret_idx_i == IDX));
  end

  assign valid_d = (valid_q & ~drop) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) if (hit[i]) mem[i] <= sel[i];
  end

  assign valid_o    = valid_q;
  assign rd_entry_o = mem[rd_idx_i];

  // R5
  ret_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_en_i |-> valid_q[ret_idx_i]);
endmodule

// File: rtl/fetch_window_queue.sv
module fetch_window_queue
  import fwq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int HALF  = DEPTH / 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   smt_req,
  input  logic                                   alloc_valid,
  input  logic                                   alloc_tid,
  input  logic [N_W-1:0]                         alloc_cnt,
  input  logic [LINE_W-1:0]                      alloc_line,
  input  logic [MAX_ALLOC*BR_PER_ENT-1:0]        alloc_br_vld,
  input  logic [MAX_ALLOC*BR_PER_ENT*OFF_W-1:0]  alloc_br_off,
  output logic                                   alloc_ok,
  output logic                                   alloc_stall,
  output logic [PTR_W-1:0]                       alloc_idx,
  input  logic                                   retire_valid,
  input  logic                                   retire_tid,
  output logic                                   head_valid,
  output logic [PTR_W-1:0]                       head_idx,
  output logic [LINE_W-1:0]                      head_line,
  output logic                                   head_last,
  output logic                                   head_tid,
  output logic [BR_PER_ENT-1:0]                  head_br_vld,
  output logic [BR_PER_ENT*OFF_W-1:0]            head_br_off,
  input  logic                                   flush_valid,
  input  logic                                   flush_tid,
  input  logic [PTR_W-1:0]                       flush_idx,
  output logic [1:0]                             full,
  output logic                                   smt_mode
);
  logic                            smt_q, mode_chg;
  logic [PTR_W-1:0]                mask, flush_off;
  logic [CNT_W-1:0]                psize, free_cnt;
  logic [1:0]                      active, ret_do, fl_do, al_do;
  logic [1:0][PTR_W-1:0]           base, head, tail;
  logic [1:0][CNT_W-1:0]           cnt, keep;
  logic                            cnt_ok;
  logic [MAX_ALLOC-1:0]            wr_en;
  logic [MAX_ALLOC-1:0][PTR_W-1:0] wr_idx;
  fw_entry_t [MAX_ALLOC-1:0]       wr_data;
  logic [DEPTH-1:0]                valid_vec;
  fw_entry_t                       rd_entry;

  assign mask      = smt_q ? PTR_W'(HALF - 1) : PTR_W'(DEPTH - 1);
  assign psize     = smt_q ? CNT_W'(HALF) : CNT_W'(DEPTH);
  assign flush_off = flush_idx & mask;

  for (genvar t = 0; t < 2; t++) begin : g_thr
    assign active[t] = (t == 0) || smt_q;
    assign base[t]   = (t == 1 && smt_q) ? PTR_W'(HALF) : '0;
    assign ret_do[t] = retire_valid && (retire_tid == 1'(t)) && active[t] && (cnt[t] != '0);
    assign fl_do[t]  = flush_valid && (flush_tid == 1'(t)) && active[t] && (cnt[t] != '0);
    assign al_do[t]  = alloc_ok && (alloc_tid == 1'(t));
    assign full[t]   = !active[t] || (cnt[t] == psize);

    fwq_ptr_ctl #(.PTR_W(PTR_W), .CNT_W(CNT_W), .N_W(N_W)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (mode_chg),
      .mask_i     (mask),
      .psize_i    (psize),
      .alloc_i    (al_do[t]),
      .alloc_n_i  (alloc_cnt),
      .retire_i   (ret_do[t]),
      .flush_i    (fl_do[t]),
      .flush_off_i(flush_off),
      .head_o     (head[t]),
      .tail_o     (tail[t]),
      .cnt_o      (cnt[t]),
      .keep_o     (keep[t])
    );
  end

  assign free_cnt    = psize - cnt[alloc_tid];
  assign cnt_ok      = (alloc_cnt != '0) && (alloc_cnt <= N_W'(MAX_ALLOC));
  assign alloc_ok    = alloc_valid && active[alloc_tid] && cnt_ok &&
                       !(flush_valid && (flush_tid == alloc_tid)) &&
                       (free_cnt >= CNT_W'(alloc_cnt));
  assign alloc_stall = alloc_valid && !alloc_ok;
  assign alloc_idx   = base[alloc_tid] | tail[alloc_tid];

  assign mode_chg = (smt_req != smt_q) && (cnt[0] == '0) && (cnt[1] == '0) && !alloc_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        smt_q <= 1'b0;
    else if (mode_chg) smt_q <= smt_req;
  end

  for (genvar k = 0; k < MAX_ALLOC; k++) begin : g_slot
    assign wr_en[k]          = alloc_ok && (N_W'(k) < alloc_cnt);
    assign wr_idx[k]         = base[alloc_tid] | ((tail[alloc_tid] + PTR_W'(k)) & mask);
    assign wr_data[k].line   = alloc_line;
    assign wr_data[k].tid    = alloc_tid;
    assign wr_data[k].last   = (N_W'(k + 1) == alloc_cnt);
    assign wr_data[k].br_vld = alloc_br_vld[k*BR_PER_ENT +: BR_PER_ENT];
    assign wr_data[k].br_off = alloc_br_off[k*BR_PER_ENT*OFF_W +: BR_PER_ENT*OFF_W];
  end

  assign head_idx = base[retire_tid] | head[retire_tid];

  fwq_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .ret_en_i  (|ret_do),
    .ret_idx_i (head_idx),
    .fl_en_i   (fl_do),
    .fl_head_i (head),
    .fl_keep_i (keep),
    .mask_i    (mask),
    .smt_i     (smt_q),
    .rd_idx_i  (head_idx),
    .valid_o   (valid_vec),
    .rd_entry_o(rd_entry)
  );

  assign head_valid  = active[retire_tid] && valid_vec[head_idx];
  assign head_line   = rd_entry.line;
  assign head_last   = rd_entry.last;
  assign head_tid    = rd_entry.tid;
  assign head_br_vld = rd_entry.br_vld;
  assign head_br_off = rd_entry.br_off;
  assign smt_mode    = smt_q;

  // R8
  mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smt_q != $past(smt_q)) |-> ($past(cnt[0]) == '0 && $past(cnt[1]) == '0));
  // R6
  full_noalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> !full[alloc_tid]);
  // R5
  head_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_valid == (active[retire_tid] && cnt[retire_tid] != '0));
  // R2
  valid_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_vec) == (32'(cnt[0]) + 32'(cnt[1])));
endmodule

// File: tb/fetch_window_queue_tb_top.sv
`timescale 1ns/1ps
module fetch_window_queue_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smt_req, alloc_valid, alloc_tid, retire_valid, retire_tid;
  logic        flush_valid, flush_tid;
  logic [2:0]  alloc_cnt;
  logic [25:0] alloc_line;
  logic [7:0]  alloc_br_vld;
  logic [47:0] alloc_br_off;
  logic [5:0]  flush_idx;
  logic        alloc_ok, alloc_stall, head_valid, head_last, head_tid, smt_mode;
  logic [5:0]  alloc_idx, head_idx;
  logic [25:0] head_line;
  logic [1:0]  head_br_vld, full;
  logic [11:0] head_br_off;

  always #2.5 clk = ~clk;

  fetch_window_queue dut_i (
    .clk(clk), .rst_n(rst_n), .smt_req(smt_req),
    .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_cnt(alloc_cnt),
    .alloc_line(alloc_line), .alloc_br_vld(alloc_br_vld), .alloc_br_off(alloc_br_off),
    .alloc_ok(alloc_ok), .alloc_stall(alloc_stall), .alloc_idx(alloc_idx),
    .retire_valid(retire_valid), .retire_tid(retire_tid),
    .head_valid(head_valid), .head_idx(head_idx), .head_line(head_line),
    .head_last(head_last), .head_tid(head_tid), .head_br_vld(head_br_vld),
    .head_br_off(head_br_off), .flush_valid(flush_valid), .flush_tid(flush_tid),
    .flush_idx(flush_idx), .full(full), .smt_mode(smt_mode)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int mh[2], mt[2], mc[2];
  bit msmt, mreq;
  logic [25:0] mline [64];
  logic        mlast [64];
  logic        mtid  [64];
  logic [1:0]  mbv   [64];
  logic [11:0] mbo   [64];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit act_t(int t); return (t == 0) || msmt; endfunction
  function automatic int msk(); return msmt ? 31 : 63; endfunction
  function automatic int psz(); return msmt ? 32 : 64; endfunction
  function automatic int bs(int t); return (msmt && t == 1) ? 32 : 0; endfunction

  task automatic step(input bit av, input int tid, input int cnt, input int line,
                      input bit rv, input int rtid,
                      input bit fv = 0, input int ftid = 0, input int fidx = 0);
    bit acc, hv, rok, fok;
    int hp, c0, c1;
    logic [1:0] fexp;
    @(negedge clk);
    smt_req = mreq;
    alloc_valid = av; alloc_tid = 1'(tid); alloc_cnt = 3'(cnt); alloc_line = 26'(line);
    alloc_br_vld = 8'(line * 5 + 1);
    for (int j = 0; j < 8; j++) alloc_br_off[j*6 +: 6] = 6'(line + j * 9);
    retire_valid = rv; retire_tid = 1'(rtid);
    flush_valid = fv; flush_tid = 1'(ftid); flush_idx = 6'(fidx);
    #1;
    acc = av && act_t(tid) && cnt >= 1 && cnt <= 4 && !(fv && ftid == tid) &&
          (psz() - mc[tid]) >= cnt;
    chk(alloc_ok === acc, "R2 alloc_ok", 64'(alloc_ok), 64'(acc));
    chk(alloc_stall === (av && !acc), "R2 alloc_stall", 64'(alloc_stall), 64'(av && !acc));
    if (acc) chk(alloc_idx == 6'(bs(tid) + mt[tid]), "R3 alloc_idx", 64'(alloc_idx), 64'(bs(tid) + mt[tid]));
    hv = act_t(rtid) && mc[rtid] > 0;
    chk(head_valid === hv, "R5 head_valid", 64'(head_valid), 64'(hv));
    if (hv) begin
      hp = bs(rtid) + mh[rtid];
      chk(head_idx == 6'(hp), "R5 head_idx", 64'(head_idx), 64'(hp));
      chk(head_line == mline[hp], "R4 head_line", 64'(head_line), 64'(mline[hp]));
      chk(head_last == mlast[hp], "R4 head_last", 64'(head_last), 64'(mlast[hp]));
      chk(head_tid == mtid[hp], "R4 head_tid", 64'(head_tid), 64'(mtid[hp]));
      chk(head_br_vld == mbv[hp] && head_br_off == mbo[hp], "R4 head_br",
          {38'd0, head_br_vld, head_br_off}, {38'd0, mbv[hp], mbo[hp]});
    end
    fexp[0] = (mc[0] == psz());
    fexp[1] = !act_t(1) || (mc[1] == psz());
    chk(full == fexp, "R6 full", 64'(full), 64'(fexp));
    chk(smt_mode == msmt, "R8 smt_mode", 64'(smt_mode), 64'(msmt));
    @(posedge clk);
    c0 = mc[0]; c1 = mc[1];
    rok = rv && act_t(rtid) && mc[rtid] > 0;
    fok = fv && act_t(ftid) && mc[ftid] > 0;
    if (acc) begin
      for (int k = 0; k < cnt; k++) begin
        hp = bs(tid) + ((mt[tid] + k) & msk());
        mline[hp] = 26'(line); mlast[hp] = (k == cnt - 1); mtid[hp] = 1'(tid);
        mbv[hp] = alloc_br_vld[2*k +: 2]; mbo[hp] = alloc_br_off[12*k +: 12];
      end
    end
    for (int t = 0; t < 2; t++) begin
      bit r, f, a;
      int nh, fo;
      r = rok && rtid == t; f = fok && ftid == t; a = acc && tid == t;
      nh = r ? ((mh[t] + 1) & msk()) : mh[t];
      if (f) begin
        fo = fidx & msk();
        mc[t] = (((fo - mh[t]) & msk()) + 1) - int'(r);
        mt[t] = (fo + 1) & msk();
      end else begin
        if (a) mt[t] = (mt[t] + cnt) & msk();
        mc[t] = mc[t] + (a ? cnt : 0) - int'(r);
      end
      mh[t] = nh;
    end
    if (mreq != msmt && c0 == 0 && c1 == 0 && !acc) begin
      msmt = mreq;
      for (int t = 0; t < 2; t++) begin mh[t] = 0; mt[t] = 0; mc[t] = 0; end
    end
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int i, ft, fi;
    rst_n = 1'b0; smt_req = 0; alloc_valid = 0; alloc_tid = 0; alloc_cnt = 0;
    alloc_line = 0; alloc_br_vld = 0; alloc_br_off = 0; retire_valid = 0;
    retire_tid = 0; flush_valid = 0; flush_tid = 0; flush_idx = 0;
    msmt = 0; mreq = 0;
    for (int t = 0; t < 2; t++) begin mh[t] = 0; mt[t] = 0; mc[t] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R1 reset state
    chk(full == 2'b10, "R1 full", 64'(full), 64'(2'b10));
    chk(head_valid == 1'b0, "R1 head_valid", 64'(head_valid), 0);
    chk(smt_mode == 1'b0, "R1 smt_mode", 64'(smt_mode), 0);

    // R3/R6: fill single-thread partition with varied line sizes
    i = 0;
    while (mc[0] < 64) begin
      step(1, 0, (i % 4) + 1, 100 + i, 0, 0);
      i++;
    end
    step(1, 0, 1, 400, 0, 0);          // R6 stall on full
    step(1, 1, 1, 401, 1, 1);          // R9 thread 1 ignored
    // R10 alloc + retire same cycle: full, then one slot free
    step(1, 0, 1, 500, 1, 0);
    step(1, 0, 1, 501, 1, 0);
    step(1, 0, 2, 502, 1, 0);
    // R5 drain in order, then retire on empty
    while (mc[0] > 0) step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0);
    step(1, 0, 3, 503, 0, 0);
    // R7 flush in single-thread mode
    step(1, 0, 4, 504, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, mh[0] + 4);
    step(1, 0, 2, 505, 0, 0, 1, 0, mh[0]);   // alloc blocked by flush
    step(1, 0, 2, 506, 0, 0);
    // R8 mode change held while not empty
    mreq = 1;
    idle(); idle();
    while (mc[0] > 0) step(0, 0, 0, 0, 1, 0);
    idle(); idle();
    // dual-thread mixed run
    for (int n = 0; n < 600; n++) begin
      int c, rt;
      c = ((n * 7) % 4) + 1;
      if (n % 23 == 5) c = 5;
      if (n % 29 == 3) c = 0;
      rt = (n / 2) % 2;
      ft = (n / 13) % 2;
      fi = 0;
      if (mc[ft] > 0) fi = bs(ft) + ((mh[ft] + (mc[ft] - 1) / ((n % 3) + 1)) & msk());
      step(1, n % 2, c, 1000 + n, (n % 3) != 0, rt, (n % 13) == 6, ft, fi);
    end
    // drain both and return to single-thread mode
    while (mc[0] > 0 || mc[1] > 0) begin
      step(0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 1, 1);
    end
    mreq = 0;
    idle(); idle();
    step(1, 0, 1, 2000, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule